// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter with a 24-bit count. Software sets it up through a small 32-bit register port. A control register enables the count, arms the interrupt, and selects the count source. The source is either every cycle of the processor clock or a single-cycle reference tick input. A reload register sets the period, and reading the current-value register gives the live count.

When the count is zero and a tick arrives, the counter reloads and sets a sticky count flag. If the interrupt is armed, it also drives a one-cycle exception request. Reading the control register clears the flag. Writing any value to the current-value register restarts the count and clears the flag. A reload value of zero makes the counter stop itself at its next expiry. A read-only calibration register returns a fixed value set by a parameter.

Top module: `tick_timer`

## Requirements
- R1: The control register is at byte offset 0x10. Bit 0 enables the count, bit 1 arms the interrupt, bit 2 selects the source (1 = every clock cycle, 0 = cycles with `ref_tick_i` high), and bit 16 is the count flag. Software can write only bits 2:0, and every other bit reads as zero.
- R2: A read of the control register returns the flag and then clears it. If an expiry happens in the same cycle as the read, the flag stays set.
- R3: Writing bit 0 from 0 to 1 loads the reload value into the count. The count then steps down once per tick, and each expiry comes reload+1 ticks after the previous load or expiry. At expiry the count is reloaded.
- R4: With source = 1 the count steps every clock cycle. With source = 0 it steps only in cycles where `ref_tick_i` is high, and it holds in all other cycles.
- R5: Every expiry sets the count flag. When the interrupt is armed, `irq_o` is high for exactly the one cycle after the expiry edge. When the interrupt is not armed, `irq_o` stays low.
- R6: If the reload value is zero at expiry, the counter clears its own enable bit.
- R7: A write of any data to the current-value register (offset 0x18) reloads the count and clears the count flag.
- R8: While the count is disabled, it holds its value and a read of the current-value register returns zero.
- R9: A control write that changes the source bit while the count stays enabled reloads the count.
- R10: The reload register (offset 0x14) and the current-value register are 24 bits wide, and bits 31:24 read as zero. The calibration register (offset 0x1C) returns the `CALIB_VAL` parameter and ignores writes. Unmapped offsets read as zero.
- R11: A reload value written while the counter runs takes effect only at the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Single-cycle reference tick enable, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; has side effects on the flag |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as rd_en_i |
| irq_o | output | 1 | One-cycle exception request on expiry |

## Verification
The bench sweeps reload values from 1 to 6 under both count sources. On the processor clock it checks that the first period and the steady period are both reload+1 cycles. With a reference tick every third cycle it checks that the period is three times as long, which separates correct tick gating from free running. Separate sequences cover a zero reload, where the counter must stop after one expiry. They also cover an unarmed interrupt, a mid-period reload change (old period first, new period after), a source switch with the reference tick held low (reload then hold), and a write to the current value, where a reload must be told apart from a plain flag clear. The read-clears-flag rule is checked by reading the control register twice in a row.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam logic [11:0] OFF_CTRL    = 12'h010;
  localparam logic [11:0] OFF_RELOAD  = 12'h014;
  localparam logic [11:0] OFF_CURRENT = 12'h018;
  localparam logic [11:0] OFF_CALIB   = 12'h01C;

  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CURRENT,
    SEL_CALIB
  } reg_sel_e;
endpackage

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_i,
  input  logic             ref_tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] count_q;
  logic             tick;
  logic             at_zero;

  assign tick    = en_i && (src_i || ref_tick_i);
  assign at_zero = (count_q == '0);
  // a load in the same cycle wins over a tick
  assign fire_o  = tick && at_zero && !load_i;
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (load_i) begin
      count_q <= reload_i;
    end else if (tick) begin
      count_q <= at_zero ? reload_i : count_q - 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          CNT_W     = 24,
  parameter logic [31:0] CALIB_VAL = 32'h4000_2710
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              fire_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              en_o,
  output logic              src_o,
  output logic              flag_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic             wr_ctrl, wr_rld, wr_cur, rd_ctrl;
  logic             en_q, ie_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0] reload_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == OFF_CTRL[ADDR_W-1:0])         sel = SEL_CTRL;
    else if (addr_i == OFF_RELOAD[ADDR_W-1:0])  sel = SEL_RELOAD;
    else if (addr_i == OFF_CURRENT[ADDR_W-1:0]) sel = SEL_CURRENT;
    else if (addr_i == OFF_CALIB[ADDR_W-1:0])   sel = SEL_CALIB;
  end

  assign wr_ctrl = wr_en_i && (sel == SEL_CTRL);
  assign wr_rld  = wr_en_i && (sel == SEL_RELOAD);
  assign wr_cur  = wr_en_i && (sel == SEL_CURRENT);
  assign rd_ctrl = rd_en_i && (sel == SEL_CTRL);

  // restart on enable rise, on a source switch while running, or on current write
  assign load_o = wr_cur ||
                  (wr_ctrl && wdata_i[BIT_EN] &&
                   (!en_q || (wdata_i[BIT_SRC] != src_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      src_q    <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[BIT_EN];
        ie_q  <= wdata_i[BIT_IE];
        src_q <= wdata_i[BIT_SRC];
      end else if (fire_i && (reload_q == '0)) begin
        en_q <= 1'b0;
      end
      if (fire_i)                 flag_q <= 1'b1;
      else if (rd_ctrl || wr_cur) flag_q <= 1'b0;
      if (wr_rld) reload_q <= wdata_i[CNT_W-1:0];
      irq_q <= fire_i && ie_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (sel)
        SEL_CTRL: begin
          rdata_o[BIT_EN]   = en_q;
          rdata_o[BIT_IE]   = ie_q;
          rdata_o[BIT_SRC]  = src_q;
          rdata_o[BIT_FLAG] = flag_q;
        end
        SEL_RELOAD:  rdata_o[CNT_W-1:0] = reload_q;
        SEL_CURRENT: if (en_q) rdata_o[CNT_W-1:0] = count_i;
        SEL_CALIB:   rdata_o = CALIB_VAL;
        default: ;
      endcase
    end
  end

  assign en_o     = en_q;
  assign src_o    = src_q;
  assign flag_o   = flag_q;
  assign reload_o = reload_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          CNT_W     = 24,
  parameter logic [31:0] CALIB_VAL = 32'h4000_2710
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic             ctrl_en, ctrl_src, flag, load_req, fire;
  logic [CNT_W-1:0] reload_val, count_val;

  tick_timer_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .fire_i   (fire),
    .count_i  (count_val),
    .en_o     (ctrl_en),
    .src_o    (ctrl_src),
    .flag_o   (flag),
    .load_o   (load_req),
    .reload_o (reload_val),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o)
  );

  tick_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_en),
    .src_i      (ctrl_src),
    .ref_tick_i (ref_tick_i),
    .load_i     (load_req),
    .reload_i   (reload_val),
    .count_o    (count_val),
    .fire_o     (fire)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              en,
  input logic              flag,
  input logic              load,
  input logic              fire,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  count
);
  logic rd_ctrl, rd_cur, rd_wide;
  assign rd_ctrl = rd_en_i && (addr_i == OFF_CTRL[ADDR_W-1:0]);
  assign rd_cur  = rd_en_i && (addr_i == OFF_CURRENT[ADDR_W-1:0]);
  assign rd_wide = rd_cur || (rd_en_i && (addr_i == OFF_RELOAD[ADDR_W-1:0]));

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |-> (rdata_o[15:3] == '0) && (rdata_o[31:17] == '0)); // R1
  AST_ENABLE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en) |-> (count == reload)); // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R5
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag); // R5
  AST_ZERO_RELOAD_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (reload == '0) && !wr_en_i) |=> !en); // R6
  AST_OFF_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cur && !en) |-> (rdata_o == '0)); // R8
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !load) |=> $stable(count)); // R8
  AST_WIDE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_wide |-> (rdata_o[31:CNT_W] == '0)); // R10
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_en_i (rd_en_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .en      (ctrl_en),
  .flag    (flag),
  .load    (load_req),
  .fire    (fire),
  .reload  (reload_val),
  .count   (count_val)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam logic [31:0] CALIB = 32'h4000_2710;
  localparam logic [11:0] A_CTRL = 12'h010, A_RLD = 12'h014, A_CUR = 12'h018, A_CAL = 12'h01C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        ref_on = 1'b1;
  int          cyc = 0;
  int          checks = 0, errors = 0;

  tick_timer #(.ADDR_W(12), .CNT_W(24), .CALIB_VAL(CALIB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // reference tick every third cycle when enabled
  always @(negedge clk) begin
    cyc <= cyc + 1;
    ref_tick <= ref_on && (cyc % 3 == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 400);
  endtask

  task automatic quiesce();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d);
  endtask

  initial begin
    #(10 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R5 irq after reset", {31'b0, irq}, 32'h0);
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 32'h0);
    rd(A_RLD, d);  chk("R10 reload reset", d, 32'h0);
    rd(A_CUR, d);  chk("R8 current reset", d, 32'h0);

    // R10 widths, R1 writable bits
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, d); chk("R10 reload upper bits", d, 32'h00FF_FFFF);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R1 only bits 2:0 stick", d, 32'h0000_0007);
    rd(A_CUR, d);  chk("R10 current 24-bit count", d, 32'h00FF_FFFC);
    wr(A_CTRL, 32'h0);
    rd(A_CAL, d); chk("R10 calibration", d, CALIB);
    wr(A_CAL, 32'h1234_5678);
    rd(A_CAL, d); chk("R10 calibration ignores write", d, CALIB);
    rd(12'h000, d); chk("R10 unmapped read", d, 32'h0);
    rd(12'h020, d); chk("R10 unmapped read", d, 32'h0);

    // R3/R4 period sweep over both sources
    for (int src = 1; src >= 0; src--) begin
      for (int r = 1; r <= 6; r++) begin
        wr(A_RLD, r);
        wr(A_CTRL, 32'h3 | (src << 2));
        wait_irq(n);
        if (src == 1) chk("R3 first period", n, r + 1);
        wait_irq(n);
        chk(src == 1 ? "R3 steady period clock" : "R4 steady period ref tick",
            n, src == 1 ? r + 1 : 3 * (r + 1));
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d); chk("R2 flag after expiry", d, 32'h0001_0000);
        rd(A_CTRL, d); chk("R2 flag cleared by read", d, 32'h0);
      end
    end

    // R5 unarmed interrupt
    wr(A_RLD, 3);
    wr(A_CTRL, 32'h5);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (irq) cnt++; end
    chk("R5 no irq when unarmed", cnt, 0);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); chk("R5 flag set when unarmed", d, 32'h0001_0000);

    // R6 zero reload stops after one expiry
    wr(A_RLD, 0);
    wr(A_CTRL, 32'h7);
    wait_irq(n); chk("R6 zero reload expires after one tick", n, 1);
    rd(A_CTRL, d); chk("R6 enable self-cleared", d, 32'h0001_0006);
    rd(A_CUR, d);  chk("R8 disabled current reads zero", d, 32'h0);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (irq) cnt++; end
    chk("R6 stays stopped", cnt, 0);

    // R7 write to current reloads and clears flag
    wr(A_RLD, 3);
    wr(A_CTRL, 32'h7);
    wait_irq(n);
    wr(A_CUR, 32'hDEAD_BEEF);
    rd(A_CUR, d);  chk("R7 current write reloads", d, 32'h2);
    rd(A_CTRL, d); chk("R7 current write clears flag", d, 32'h7);
    quiesce();

    // R9 source switch reloads; R4 no ticks without reference
    ref_on = 1'b0;
    wr(A_RLD, 50);
    wr(A_CTRL, 32'h5);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, d); chk("R9 source switch reloads", d, 32'd50);
    repeat (5) @(negedge clk);
    rd(A_CUR, d); chk("R4 holds without reference tick", d, 32'd50);
    ref_on = 1'b1;
    quiesce();

    // R11 reload change takes effect at next expiry
    wr(A_RLD, 4);
    wr(A_CTRL, 32'h7);
    wait_irq(n); chk("R3 period reload 4", n, 5);
    wr(A_RLD, 9);
    wait_irq(n); chk("R11 old period kept (2 cycles spent in write)", n, 3);
    wait_irq(n); chk("R11 new period after expiry", n, 10);
    quiesce();

    // R8 disabled read
    rd(A_CUR, d); chk("R8 disabled current reads zero", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule